// File: doc/BRIEF.md
# Single-Line Request/Grant Bus Handover Arbiter

This block lets an external bus master borrow the processor's bus. In request/grant mode each channel is one active-low line that both sides can pull. The other master pulls the line low for one clock to ask for the bus. The arbiter answers on the same line with a one-clock low grant pulse, and the other master later returns the bus with a one-clock low release pulse. Two such channels are provided.

In hold mode the line protocol is replaced by a plain pair of active-high levels: a hold request coming in and a hold acknowledge going out.

The arbiter does not drive any pins itself. It sees the already-sampled line levels, a flag from the cycle sequencer that the current bus cycle is at T4 or the bus is idle, and the processor's LOCK state. It produces three things:
- per-channel enables that pull each line low;
- a float command that tells the cycle sequencer to release the address, data, status, RD and LOCK outputs;
- the hold-acknowledge level.

Top module: `rqgt_arbiter`

## Requirements
- R1: While reset is high, and in the first clock after it, all line drive enables are 0, the float command is 0 and the hold acknowledge is 0.
- R2: In request/grant mode, a line sampled low while the arbiter is idle records a request on that channel. The arbiter then drives that channel's enable, and only that channel's enable, for exactly one clock as the grant pulse.
- R3: The grant pulse starts in the clock after an edge at which a request is pending and the cycle-boundary flag is 1. While the flag is 0, no grant is driven.
- R4: While LOCK is asserted, a pending request is held and no grant is driven. The grant follows the first qualifying edge after LOCK drops.
- R5: The float command is 1 from the grant-pulse clock until the edge at which the granted channel's line is sampled low, which is the release pulse. The command returns to 0 in the clock after that edge.
- R6: While the other master owns the bus, low pulses on the other channel are ignored. After ownership returns, no grant follows from them.
- R7: If both channels are sampled low at the same idle edge, channel 0 is granted and the channel 1 request is dropped.
- R8: In hold mode, the hold acknowledge rises in the clock after an edge where the hold request and the cycle-boundary flag are both 1. It falls in the clock after the hold request is sampled 0. The float command equals the hold acknowledge in this mode.
- R9: In hold mode the request/grant lines are ignored and never driven. In request/grant mode the hold request is ignored and the hold acknowledge stays 0.
- R10: At most one line drive enable is 1 in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_max | input | 1 | 1 selects request/grant mode, 0 selects hold mode; a static strap |
| rq_n_in | input | NCH | Sampled levels of the request/grant lines, low means pulled |
| cyc_boundary | input | 1 | Current bus cycle is at T4 or the bus is idle |
| lock_act | input | 1 | Processor holds bus LOCK |
| hold_req | input | 1 | Hold request, active high |
| rq_drive_low | output | NCH | Enable to pull each line low (grant pulse) |
| bus_float | output | 1 | Command to float the processor's bus outputs |
| hlda | output | 1 | Hold acknowledge, active high |

## Verification
The properties assume the following about the inputs:
- The mode strap stays constant after reset.
- The line inputs already meet setup time against the clock and are synchronous.
- The other master pulls a line low only for single-clock pulses, in the order request then release.

The stimulus follows these rules. Each pulse is driven for exactly one clock, on the falling edge. Each line is modelled as the wired-AND of the arbiter's enable and the other master's pull. The mode is changed only while the arbiter is idle and is followed by a reset-free idle clock.

// File: rtl/rqgt_arbiter.sv
module rqgt_arbiter #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           mode_max,
  input  logic [NCH-1:0] rq_n_in,
  input  logic           cyc_boundary,
  input  logic           lock_act,
  input  logic           hold_req,
  output logic [NCH-1:0] rq_drive_low,
  output logic           bus_float,
  output logic           hlda
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_GRANT, S_OWNED, S_HOLD} st_t;

  st_t st, st_nx;
  logic [CW-1:0] ch, ch_nx, pick;
  logic any_req;

  always_comb begin
    any_req = |(~rq_n_in);
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (!rq_n_in[i]) pick = CW'(i);
  end

  always_comb begin
    st_nx = st;
    ch_nx = ch;
    case (st)
      S_IDLE:
        if (mode_max && any_req) begin
          st_nx = S_PEND;
          ch_nx = pick;
        end else if (!mode_max && hold_req && cyc_boundary) begin
          st_nx = S_HOLD;
        end
      S_PEND:  if (cyc_boundary && !lock_act) st_nx = S_GRANT;
      S_GRANT: st_nx = S_OWNED;
      S_OWNED: if (!rq_n_in[ch]) st_nx = S_IDLE;
      S_HOLD:  if (!hold_req) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      ch <= '0;
    end else begin
      st <= st_nx;
      ch <= ch_nx;
    end
  end

  assign rq_drive_low = (st == S_GRANT) ? (NCH'(1) << ch) : '0;
  assign bus_float    = (st == S_GRANT) || (st == S_OWNED) || (st == S_HOLD);
  assign hlda         = (st == S_HOLD);
endmodule

// File: rtl/rqgt_arbiter_chk.sv
module rqgt_arbiter_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           mode_max,
  input logic [NCH-1:0] rq_n_in,
  input logic           cyc_boundary,
  input logic           lock_act,
  input logic           hold_req,
  input logic [NCH-1:0] rq_drive_low,
  input logic           bus_float,
  input logic           hlda
);
  p_onehot_drive_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rq_drive_low));

  p_grant_one_clock_r2: assert property (@(posedge clk) disable iff (rst)
    (|rq_drive_low) |=> (rq_drive_low == '0));

  p_grant_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
    (|rq_drive_low) |-> $past(cyc_boundary));

  p_no_grant_locked_r4: assert property (@(posedge clk) disable iff (rst)
    (|rq_drive_low) |-> !$past(lock_act));

  p_float_with_grant_r5: assert property (@(posedge clk) disable iff (rst)
    (|rq_drive_low) |-> bus_float);

  p_hlda_floats_r8: assert property (@(posedge clk) disable iff (rst)
    hlda |-> bus_float);

  p_hlda_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!mode_max && !bus_float && hold_req && cyc_boundary) |=> hlda);

  p_hlda_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (hlda && !hold_req) |=> !hlda);

  p_mode_split_r9: assert property (@(posedge clk) disable iff (rst)
    (mode_max |-> !hlda) and (!mode_max |-> (rq_drive_low == '0)));
endmodule

bind rqgt_arbiter rqgt_arbiter_chk #(.NCH(NCH)) chk_i (.*);

// File: tb/rqgt_arbiter_tb_top.sv
module rqgt_arbiter_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic mode_max = 1;
  logic cyc_boundary = 1;
  logic lock_act = 0;
  logic hold_req = 0;
  logic [1:0] pull = 2'b00;
  logic [1:0] rq_drive_low;
  logic bus_float, hlda;
  wire  [1:0] line_n = ~(rq_drive_low | pull);

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rqgt_arbiter #(.NCH(2)) dut_i (
    .clk(clk), .rst(rst), .mode_max(mode_max), .rq_n_in(line_n),
    .cyc_boundary(cyc_boundary), .lock_act(lock_act), .hold_req(hold_req),
    .rq_drive_low(rq_drive_low), .bus_float(bus_float), .hlda(hlda)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [1:0] drv, logic flt, logic hl);
    vecs++;
    if (rq_drive_low !== drv || bus_float !== flt || hlda !== hl) begin
      errs++;
      $display("FAIL %s: drive=%b float=%b hlda=%b expected drive=%b float=%b hlda=%b",
               tag, rq_drive_low, bus_float, hlda, drv, flt, hl);
    end
  endtask

  task automatic pulse(logic [1:0] p);
    pull = p;
    tick();
    pull = 2'b00;
  endtask

  task automatic handover(int ch, int bd, int ld);
    logic [1:0] g = 2'(1 << ch);
    bit granted = 0;
    pulse(g);
    chk("R2 request latched, no drive yet", 2'b00, 0, 0);
    for (int k = 0; !granted; k++) begin
      cyc_boundary = (k >= bd);
      lock_act = (k < ld);
      tick();
      if (cyc_boundary && !lock_act) begin
        granted = 1;
        chk("R2 grant pulse on requesting channel", g, 1, 0);
      end else if (lock_act) chk("R4 grant withheld under lock", 2'b00, 0, 0);
      else chk("R3 grant waits for cycle boundary", 2'b00, 0, 0);
    end
    cyc_boundary = 1;
    lock_act = 0;
    tick();
    chk("R2 grant lasts one clock", 2'b00, 1, 0);
    pulse(~g);
    chk("R6 other channel ignored while owned", 2'b00, 1, 0);
    tick();
    chk("R5 float held until release", 2'b00, 1, 0);
    pulse(g);
    chk("R5 bus returned after release", 2'b00, 0, 0);
    tick();
    tick();
    chk("R6 ignored request not granted later", 2'b00, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 2'b00, 0, 0);
    rst = 0;
    tick();
    chk("R1 first clock after reset", 2'b00, 0, 0);

    for (int ch = 0; ch < 2; ch++)
      for (int bd = 0; bd < 4; bd++)
        for (int ld = 0; ld < 4; ld++)
          handover(ch, bd, ld);

    pulse(2'b11);
    chk("R7 simultaneous request pending", 2'b00, 0, 0);
    tick();
    chk("R7 channel 0 wins", 2'b01, 1, 0);
    tick();
    pulse(2'b01);
    chk("R7 released", 2'b00, 0, 0);
    tick();
    tick();
    chk("R7 channel 1 request dropped", 2'b00, 0, 0);

    hold_req = 1;
    tick();
    chk("R9 hold ignored in request/grant mode", 2'b00, 0, 0);
    hold_req = 0;
    tick();

    mode_max = 0;
    tick();
    pulse(2'b11);
    chk("R9 lines ignored in hold mode", 2'b00, 0, 0);
    tick();
    chk("R9 no grant in hold mode", 2'b00, 0, 0);
    for (int bd = 0; bd < 3; bd++) begin
      hold_req = 1;
      for (int k = 0; k <= bd; k++) begin
        cyc_boundary = (k == bd);
        tick();
        if (k == bd) chk("R8 hlda rises at boundary", 2'b00, 1, 1);
        else chk("R8 hlda waits for boundary", 2'b00, 0, 0);
      end
      cyc_boundary = 1;
      pulse(2'b10);
      chk("R9 lines ignored while held", 2'b00, 1, 1);
      hold_req = 0;
      tick();
      chk("R8 hlda falls after hold drops", 2'b00, 0, 0);
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule